// File: doc/BRIEF.md
# Permit Loop Carrier Node

This block is one node on a set of optical permit loops. Each loop carries a fixed-frequency square wave. As long as the wave reaches the end of the loop, beam is permitted. Any node may cut the wave, and every node can watch it. Each loop lane forwards the wave only while the node's local permit is high. Each lane also judges whether a carrier of the right frequency is arriving at its input, and reports the result on its own permit-info flag. The lanes are separate, identical copies of the same logic: one lane per loop, two by default, one for each direction of travel. No lane shares a flip-flop or a decision with another lane.

A node can also be strapped as the loop origin. In that mode, each lane sends out its own locally generated carrier instead of relaying its input. The node raises a dump request whenever any lane has lost its returning carrier. Carrier presence is judged by measuring the number of local clock cycles between rising edges on the synchronised input. The nominal ratio is four local cycles per carrier period, which gives a 40 MHz sample clock for a 10 MHz carrier. An input that is stuck high, stuck low, too fast or too slow counts as carrier absent.

The block has no streaming data interface. Every pin is a plain level, so there is no valid/ready handshake and no back-pressure: the outputs follow the inputs with the fixed latencies given below.

Top module: `permit_loop_node`

## Requirements
- R1: While `local_permit` is low, every bit of `loop_out` is 0 from the first clock edge that samples the low permit.
- R2: With `origin_sel` low and `local_permit` high, `loop_out[i]` repeats `loop_in[i]` delayed by exactly three clock cycles (two synchroniser stages and one output register).
- R3: With `origin_sel` high and `local_permit` high, `loop_out[i]` is a square wave with a period of 4 cycles (2 high, 2 low), regardless of `loop_in`.
- R4: A rising-edge interval from 3 to 5 cycles inclusive counts as valid. With the default parameters, these bounds are the ±20 % window around 4 cycles, widened outward to whole cycles. A carrier whose period stays in this range keeps `permit_info[i]` high.
- R5: After reset, `permit_info[i]` is 0. It stays 0 until 16 consecutive valid intervals have been measured, which takes 17 rising edges. It goes to 1 when the 16th valid interval is measured.
- R6: If `loop_in[i]` stops toggling (stuck high or stuck low), `permit_info[i]` falls within 10 cycles of the last rising input edge.
- R7: An interval shorter than 3 cycles (over-frequency) clears `permit_info[i]` and restarts the count of valid intervals.
- R8: An interval longer than 5 cycles (under-frequency) clears `permit_info[i]` and restarts the count of valid intervals.
- R9: With `origin_sel` high, `dump_req` is 1 one cycle after any `permit_info` bit is 0, and 0 one cycle after all bits are 1. During reset, `dump_req` is 1.
- R10: With `origin_sel` low, `dump_req` is 0 one cycle after the select is sampled.
- R11: The lanes are independent: losing the carrier on one loop does not change another loop's `permit_info` or `loop_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sample clock (nominally 4x carrier) |
| rst_n | input | 1 | Asynchronous active-low reset |
| origin_sel | input | 1 | 1: node generates the carrier and may request a dump; 0: relay node |
| local_permit | input | 1 | Local permit; 1 lets the carrier pass |
| loop_in | input | NUM_LOOPS | Incoming loop carrier, one bit per loop |
| loop_out | output | NUM_LOOPS | Outgoing loop carrier, one bit per loop |
| permit_info | output | NUM_LOOPS | 1 while a valid carrier is locked on that loop's input |
| dump_req | output | 1 | Dump request at the origin when any loop carrier is absent |

## Verification
The hardest case to reach from the ports is the lock boundary. The flag must still be low after exactly fifteen valid intervals and must rise on the sixteenth. Because of the two-stage synchroniser, this boundary is only visible three cycles after the input edge that causes it. The bench drives cycle-exact waveforms from a clean stuck-low state, so the edge that completes the sixteenth interval falls at a known time. It then checks the flag low just before that edge takes effect and high one period later. The same waveform driver places intervals of exactly 2, 3, 5 and 6 cycles to probe both edges of the acceptance window. The origin path is closed by looping the outputs back to the inputs, so that dropping the local permit must starve both lanes and raise the dump request.

// File: rtl/permit_loop_pkg.sv
package permit_loop_pkg;

  // Shortest accepted rising-edge interval in sample cycles (rounded down, never 0).
  function automatic int unsigned gap_min(input int unsigned spp, input int unsigned tol_pct);
    int unsigned v;
    v = (spp * (100 - tol_pct)) / 100;
    if (v < 1) v = 1;
    return v;
  endfunction

  // Longest accepted rising-edge interval in sample cycles (rounded up).
  function automatic int unsigned gap_max(input int unsigned spp, input int unsigned tol_pct);
    return (spp * (100 + tol_pct) + 99) / 100;
  endfunction

  typedef enum logic {
    SRC_RELAY  = 1'b0,
    SRC_ORIGIN = 1'b1
  } loop_src_e;

endpackage

// File: rtl/loop_sync_edge.sv
module loop_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], raw};
  end

  assign level = sh_q[STAGES-1];
  assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/loop_carrier_gen.sv
module loop_carrier_gen #(
  parameter int unsigned SPP = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic wave
);
  localparam int unsigned PW = (SPP > 1) ? $clog2(SPP) : 1;
  localparam logic [PW-1:0] LAST = PW'(SPP - 1);
  localparam logic [PW-1:0] HALF = PW'(SPP / 2);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                    phase_q <= phase_q + 1'b1;
  end

  assign wave = (phase_q < HALF);
endmodule

// File: rtl/loop_period_monitor.sv
module loop_period_monitor
  import permit_loop_pkg::*;
#(
  parameter int unsigned SPP          = 4,
  parameter int unsigned TOL_PCT      = 20,
  parameter int unsigned LOCK_PERIODS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  output logic carrier_ok
);
  localparam int unsigned MIN_I = gap_min(SPP, TOL_PCT);
  localparam int unsigned MAX_I = gap_max(SPP, TOL_PCT);
  localparam int unsigned CW    = $clog2(MAX_I + 2);
  localparam int unsigned RW    = $clog2(LOCK_PERIODS + 1);
  localparam logic [CW-1:0] GAP_LO  = CW'(MIN_I);
  localparam logic [CW-1:0] GAP_HI  = CW'(MAX_I);
  localparam logic [CW-1:0] GAP_SAT = CW'(MAX_I + 1);
  localparam logic [RW-1:0] RUN_TOP = RW'(LOCK_PERIODS);

  logic [CW-1:0] gap_q;
  logic [RW-1:0] run_q;
  logic          in_range;

  assign in_range = (gap_q >= GAP_LO) && (gap_q <= GAP_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= GAP_SAT;
      run_q <= '0;
    end else if (rise) begin
      gap_q <= CW'(1);
      if (!in_range)             run_q <= '0;
      else if (run_q != RUN_TOP) run_q <= run_q + 1'b1;
    end else begin
      if (gap_q != GAP_SAT) gap_q <= gap_q + 1'b1;
      // no edge by the last acceptable cycle: carrier is gone
      if (gap_q >= GAP_HI) run_q <= '0;
    end
  end

  assign carrier_ok = (run_q == RUN_TOP);
endmodule

// File: rtl/loop_lane.sv
module loop_lane
  import permit_loop_pkg::*;
#(
  parameter int unsigned SPP          = 4,
  parameter int unsigned TOL_PCT      = 20,
  parameter int unsigned LOCK_PERIODS = 16,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic origin_sel,
  input  logic local_permit,
  input  logic lane_in,
  output logic lane_out,
  output logic lane_ok
);
  logic      synced, rise, gen_wave, src_bit, out_q;
  loop_src_e src_mode;

  loop_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(lane_in), .level(synced), .rise(rise)
  );

  loop_period_monitor #(.SPP(SPP), .TOL_PCT(TOL_PCT), .LOCK_PERIODS(LOCK_PERIODS)) u_mon (
    .clk(clk), .rst_n(rst_n), .rise(rise), .carrier_ok(lane_ok)
  );

  loop_carrier_gen #(.SPP(SPP)) u_gen (
    .clk(clk), .rst_n(rst_n), .wave(gen_wave)
  );

  assign src_mode = loop_src_e'(origin_sel);
  assign src_bit  = (src_mode == SRC_ORIGIN) ? gen_wave : synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= local_permit & src_bit;
  end

  assign lane_out = out_q;
endmodule

// File: rtl/permit_loop_node.sv
module permit_loop_node #(
  parameter int unsigned NUM_LOOPS    = 2,
  parameter int unsigned SPP          = 4,
  parameter int unsigned TOL_PCT      = 20,
  parameter int unsigned LOCK_PERIODS = 16,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 origin_sel,
  input  logic                 local_permit,
  input  logic [NUM_LOOPS-1:0] loop_in,
  output logic [NUM_LOOPS-1:0] loop_out,
  output logic [NUM_LOOPS-1:0] permit_info,
  output logic                 dump_req
);
  logic dump_q;

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_lane
    loop_lane #(
      .SPP(SPP), .TOL_PCT(TOL_PCT), .LOCK_PERIODS(LOCK_PERIODS), .SYNC_STAGES(SYNC_STAGES)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .origin_sel(origin_sel), .local_permit(local_permit),
      .lane_in(loop_in[g]), .lane_out(loop_out[g]), .lane_ok(permit_info[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dump_q <= 1'b1;
    else        dump_q <= origin_sel & ~(&permit_info);
  end

  assign dump_req = dump_q;
endmodule

// File: rtl/permit_loop_node_chk.sv
module permit_loop_node_chk
  import permit_loop_pkg::*;
#(
  parameter int unsigned NUM_LOOPS    = 2,
  parameter int unsigned SPP          = 4,
  parameter int unsigned TOL_PCT      = 20,
  parameter int unsigned LOCK_PERIODS = 16,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 origin_sel,
  input logic                 local_permit,
  input logic [NUM_LOOPS-1:0] loop_in,
  input logic [NUM_LOOPS-1:0] loop_out,
  input logic [NUM_LOOPS-1:0] permit_info,
  input logic                 dump_req
);
  localparam int unsigned QUIET_LIM = gap_max(SPP, TOL_PCT) + SYNC_STAGES + 3;
  localparam int unsigned QW        = $clog2(QUIET_LIM + 2);
  localparam int unsigned EW        = $clog2(LOCK_PERIODS + 2);

  // R10: a relay node never requests a dump
  a_r10_relay_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !origin_sel |=> !dump_req);

  // R9: origin follows the lane flags one cycle later
  a_r9_dump_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (origin_sel && !(&permit_info)) |=> dump_req);
  a_r9_no_dump_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (origin_sel && (&permit_info)) |=> !dump_req);

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_chk
    logic          prev_q;
    logic [QW-1:0] quiet_q;
    logic [EW-1:0] edges_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q  <= 1'b0;
        quiet_q <= '0;
        edges_q <= '0;
      end else begin
        prev_q <= loop_in[g];
        if (loop_in[g] != prev_q)          quiet_q <= '0;
        else if (quiet_q != QW'(QUIET_LIM + 1)) quiet_q <= quiet_q + 1'b1;
        if (loop_in[g] && !prev_q && edges_q != EW'(LOCK_PERIODS + 1))
          edges_q <= edges_q + 1'b1;
      end
    end

    // R1: a low permit closes the loop
    a_r1_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
      !local_permit |=> !loop_out[g]);

    // R6: a silent input cannot keep the flag
    a_r6_stuck_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_q > QW'(QUIET_LIM)) |-> !permit_info[g]);

    // R5: lock needs at least LOCK_PERIODS+1 rising edges since reset
    a_r5_lock_needs_edges: assert property (@(posedge clk) disable iff (!rst_n)
      permit_info[g] |-> (edges_q >= EW'(LOCK_PERIODS + 1)));
  end
endmodule

bind permit_loop_node permit_loop_node_chk #(
  .NUM_LOOPS(NUM_LOOPS), .SPP(SPP), .TOL_PCT(TOL_PCT),
  .LOCK_PERIODS(LOCK_PERIODS), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .origin_sel(origin_sel), .local_permit(local_permit),
  .loop_in(loop_in), .loop_out(loop_out), .permit_info(permit_info), .dump_req(dump_req)
);

// File: tb/permit_loop_node_test.sv
module permit_loop_node_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       origin_sel = 1'b0;
  logic       local_permit = 1'b0;
  logic       loopback = 1'b0;
  logic [1:0] drv = 2'b00;
  logic [1:0] loop_in, loop_out, permit_info;
  logic       dump_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign loop_in = loopback ? loop_out : drv;

  permit_loop_node uut (
    .clk(clk), .rst_n(rst_n), .origin_sel(origin_sel), .local_permit(local_permit),
    .loop_in(loop_in), .loop_out(loop_out), .permit_info(permit_info), .dump_req(dump_req)
  );

  typedef enum int {S_LOUT0, S_LOUT1, S_INFO0, S_INFO1, S_DUMP} sig_e;
  typedef struct {
    sig_e  sig;
    logic  exp;
    string tag;
  } item_t;
  item_t sb_q[$];

  function automatic logic read_sig(sig_e s);
    case (s)
      S_LOUT0: return loop_out[0];
      S_LOUT1: return loop_out[1];
      S_INFO0: return permit_info[0];
      S_INFO1: return permit_info[1];
      default: return dump_req;
    endcase
  endfunction

  // driver side: queue an expectation for the current negedge
  task automatic want(input sig_e s, input logic e, input string tag);
    item_t it;
    it.sig = s; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compares queued items just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic  act;
        it  = sb_q.pop_front();
        act = read_sig(it.sig);
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s %s actual=%b expected=%b", it.tag, it.sig.name(), act, it.exp);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wave(input int idx, input int hi, input int lo, input int n);
    repeat (n) begin
      repeat (hi) begin @(negedge clk); drv[idx] = 1'b1; end
      repeat (lo) begin @(negedge clk); drv[idx] = 1'b0; end
    end
  endtask

  task automatic relock0();
    drv[0] = 1'b0;
    ticks(12);
    wave(0, 2, 2, 20);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic pat [0:31];
    logic [7:0] lf;
    logic v [0:15];
    int highs, mism;

    ticks(4);
    rst_n = 1'b1;
    ticks(2);
    // reset state
    want(S_INFO0, 1'b0, "R5");
    want(S_INFO1, 1'b0, "R5");
    want(S_LOUT0, 1'b0, "R1");
    want(S_DUMP,  1'b0, "R10");

    // R5: exactly 15 valid intervals is not enough, 16 locks
    fork
      wave(0, 2, 2, 16);
      wave(1, 2, 2, 16);
    join
    want(S_INFO0, 1'b0, "R5");
    want(S_INFO1, 1'b0, "R5");
    fork
      wave(0, 2, 2, 2);
      wave(1, 2, 2, 2);
    join
    want(S_INFO0, 1'b1, "R5");
    want(S_INFO1, 1'b1, "R5");

    // R4: periods of 3 and 5 cycles stay locked
    wave(0, 1, 2, 20);
    want(S_INFO0, 1'b1, "R4");
    wave(0, 3, 2, 20);
    want(S_INFO0, 1'b1, "R4");

    // R8: period 6 is rejected
    wave(0, 3, 3, 10);
    want(S_INFO0, 1'b0, "R8");
    // R7: period 2 is rejected
    relock0();
    want(S_INFO0, 1'b1, "R7");
    wave(0, 1, 1, 10);
    want(S_INFO0, 1'b0, "R7");

    // R6: stuck high, then stuck low
    relock0();
    @(negedge clk); drv[0] = 1'b1;
    ticks(10);
    want(S_INFO0, 1'b0, "R6");
    relock0();
    ticks(10);
    want(S_INFO0, 1'b0, "R6");

    // R11: loop 0 silent while loop 1 keeps its carrier
    drv = 2'b00;
    ticks(12);
    wave(1, 2, 2, 20);
    want(S_INFO1, 1'b1, "R11");
    want(S_INFO0, 1'b0, "R11");
    fork
      begin drv[0] = 1'b0; ticks(40); end
      wave(1, 2, 2, 10);
    join
    want(S_INFO1, 1'b1, "R11");

    // R2: relay with permit high, 3-cycle latency
    @(negedge clk); local_permit = 1'b1;
    lf = 8'hA5;
    for (int k = 0; k < 32; k++) begin
      pat[k] = lf[0];
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      drv[0] = pat[k];
      drv[1] = ~pat[k];
      if (k >= 3) begin
        want(S_LOUT0, pat[k-3], "R2");
        want(S_LOUT1, ~pat[k-3], "R2");
      end
    end

    // R1: permit low closes both lanes while inputs toggle
    @(negedge clk); local_permit = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      drv = drv ^ 2'b11;
      want(S_LOUT0, 1'b0, "R1");
      want(S_LOUT1, 1'b0, "R1");
    end

    // R10: relay node with everything absent
    want(S_DUMP, 1'b0, "R10");

    // R3: origin generates its own carrier
    @(negedge clk);
    drv = 2'b11;
    origin_sel = 1'b1;
    local_permit = 1'b1;
    ticks(3);
    highs = 0; mism = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      v[k] = loop_out[0];
      if (v[k]) highs++;
      if (k >= 4 && v[k] !== v[k-4]) mism++;
      if (k >= 2 && v[k] === v[k-2]) mism++;
      if (loop_out[1] !== loop_out[0]) mism++;
    end
    check(highs == 8, "R3 high cycles", highs, 8);
    check(mism == 0, "R3 period shape", mism, 0);
    want(S_DUMP, 1'b1, "R9");

    // R9: closed ring at the origin, then permit dropped
    loopback = 1'b1;
    ticks(100);
    want(S_INFO0, 1'b1, "R9");
    want(S_INFO1, 1'b1, "R9");
    want(S_DUMP,  1'b0, "R9");
    @(negedge clk); local_permit = 1'b0;
    ticks(14);
    want(S_INFO0, 1'b0, "R9");
    want(S_DUMP,  1'b1, "R9");
    @(negedge clk); origin_sel = 1'b0;
    ticks(2);
    want(S_DUMP, 1'b0, "R10");

    ticks(2);
    done = 1'b1;
    finish_run();
  end
endmodule